// File: doc/BRIEF.md
# SPI Serial SRAM Slave

This block is the serial front end of a 32K x 8 static memory. An external master reaches it over SPI in mode 0 or mode 3, and the block always acts as the slave. It oversamples the serial pins with the system clock. It decodes the command byte and the address bytes. It then moves data between the serial lines and a synchronous single-port array, and reaches that array through a registered address, write-data and write-enable port. Reads and writes can run as bursts. The address steps by one for each data byte and wraps from the top of the array to 0x0000.

Writes are gated by several controls. A write-enable latch must be set by command. A write-protect input pin blocks all writes. Two block-protect status bits fence off part of the array. A hold input freezes a transfer in the middle and keeps its state.

A separate nonvolatile sequencer shares the array. It asks for the array with a request line, and the slave grants it while no frame is open. While that sequencer reports busy, array reads return zero, array writes are dropped, and the ready bit of the status register reads 1.

Top module: `spi_sram_slave`

## Requirements
- R1: Both SPI modes 0 and 3 work, selected by the idle level of `sck`. The block samples `mosi` on rising `sck` edges and updates `miso` on falling edges. Bits move MSB first. `clk` must run at least 8 times faster than `sck`.
- R2: Read command 0x03 is followed by a high address byte and a low address byte. Bit 7 of the high byte is ignored. The byte at that address is shifted out during the next byte time.
- R3: Fast-read command 0x0B takes the two address bytes plus one dummy byte whose value is ignored. Data starts in the byte time after the dummy byte.
- R4: Write command 0x02 takes the two address bytes and then data bytes. Each data byte is written only once all 8 of its bits have arrived. A partly shifted byte is dropped when `cs_n` rises.
- R5: In a read or write burst the address steps by one for each data byte and wraps from 0x7FFF to 0x0000.
- R6: Command 0x06 sets the write-enable latch and command 0x04 clears it. Array and status writes are ignored while the latch is clear.
- R7: The write-enable latch clears when `cs_n` rises after a write frame that carried at least one whole data byte, or after a completed status write.
- R8: Command 0x05 returns the status byte, repeated for every further byte of the frame. Bit 0 is busy/ready (1 while the sequencer is busy), bit 1 is the write-enable latch, bits 3:2 are the block-protect field, and bits 7:4 read 0.
- R9: Command 0x01 followed by one byte loads bits 3:2 of that byte into the block-protect field. This happens only if the latch is set, `wp_n` is high and the sequencer is not busy.
- R10: Block-protect value 0 protects nothing. Value 1 protects 0x6000-0x7FFF, value 2 protects 0x4000-0x7FFF, and value 3 protects the whole array. Writes to protected bytes are ignored.
- R11: While `wp_n` is low, no array or status write takes place.
- R12: While `hold_n` is low, `sck` edges are ignored, `miso_oe` is low, and the bit and byte position are kept. The transfer resumes when `hold_n` returns high.
- R13: While `nv_busy` is high, array writes are dropped and read data bytes are 0x00.
- R14: `nv_gnt` is high only while `nv_req` is high and no frame is open (`cs_n` high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the master |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low write protect |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso` |
| mem_addr | output | 15 | Array address |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, one cycle after the address |
| nv_req | input | 1 | Sequencer request for the array |
| nv_gnt | output | 1 | Grant to the sequencer |
| nv_busy | input | 1 | Sequencer store or recall in progress |

## Verification
Two events can land in the same cycle. The first is the completion of a data byte, which would write the array or load read data. The second is the sequencer holding `nv_busy`. The bench holds busy across a complete, properly enabled write frame and across a read of a location it already knows is non-zero. It judges the outcome by the status ready bit during busy, by the 0x00 returned on the read, and by a readback after busy drops that finds the target byte unchanged. A second overlap is a grant request arriving while a frame is opening: the bench checks that the grant is present while the master is idle and is withdrawn once `cs_n` is low.

// File: rtl/spi_sram_slave.sv
module spi_sram_slave #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          mosi,
  input  logic          hold_n,
  input  logic          wp_n,
  output logic          miso,
  output logic          miso_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          nv_req,
  output logic          nv_gnt,
  input  logic          nv_busy
);
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam int HI = AW - 8;

  logic [2:0] sck_p;
  logic [1:0] cs_p, mosi_p, hold_p, wp_p;
  logic [2:0] bitcnt, bidx;
  logic [7:0] sr, op, osr;
  logic [AW-1:0] addr;
  logic [1:0] bp;
  logic wel, wel_clr, rd1, rd2;

  wire cs_idle = cs_p[1];
  wire hold_s = hold_p[1];
  wire wp_s = wp_p[1];
  wire act = !cs_idle && hold_s;
  wire rise = act && sck_p[1] && !sck_p[2];
  wire fall = act && !sck_p[1] && sck_p[2];
  wire [7:0] rx = {sr[6:0], mosi_p[1]};
  wire done = rise && (bitcnt == 3'd7);
  wire [7:0] status = {4'b0000, bp, wel, nv_busy};
  wire is_rd = (op == OP_READ) || (op == OP_FAST);

  function automatic logic prot(input logic [AW-1:0] a, input logic [1:0] b);
    case (b)
      2'd0: prot = 1'b0;
      2'd1: prot = a[AW-1] && a[AW-2];
      2'd2: prot = a[AW-1];
      default: prot = 1'b1;
    endcase
  endfunction

  wire wr_ok = wel && wp_s && !nv_busy && !prot(addr, bp);

  assign miso = osr[7];
  assign miso_oe = act;
  assign nv_gnt = nv_req && cs_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      cs_p <= 2'b11;
      mosi_p <= '0;
      hold_p <= 2'b11;
      wp_p <= 2'b11;
    end else begin
      sck_p <= {sck_p[1:0], sck};
      cs_p <= {cs_p[0], cs_n};
      mosi_p <= {mosi_p[0], mosi};
      hold_p <= {hold_p[0], hold_n};
      wp_p <= {wp_p[0], wp_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      bidx <= '0;
      sr <= '0;
      op <= '0;
      osr <= '0;
      addr <= '0;
      bp <= '0;
      wel <= 1'b0;
      wel_clr <= 1'b0;
      rd1 <= 1'b0;
      rd2 <= 1'b0;
      mem_addr <= '0;
      mem_we <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      rd1 <= 1'b0;
      rd2 <= rd1;
      if (rd2) osr <= nv_busy ? 8'h00 : mem_rdata;
      if (cs_idle) begin
        bitcnt <= '0;
        bidx <= '0;
        op <= '0;
        wel_clr <= 1'b0;
        if (wel_clr) wel <= 1'b0;
      end else begin
        if (rise) begin
          sr <= rx;
          bitcnt <= bitcnt + 3'd1;
        end
        if (fall && bitcnt != 3'd0) osr <= {osr[6:0], 1'b0};
        if (done) begin
          if (bidx != 3'd7) bidx <= bidx + 3'd1;
          case (bidx)
            3'd0: begin
              op <= rx;
              if (rx == OP_WREN) wel <= 1'b1;
              if (rx == OP_WRDI) wel <= 1'b0;
              if (rx == OP_RDSR) osr <= status;
            end
            3'd1: begin
              if (op == OP_WRSR) begin
                if (wel && wp_s && !nv_busy) bp <= rx[3:2];
                wel_clr <= 1'b1;
              end else begin
                addr[AW-1:8] <= rx[HI-1:0];
              end
            end
            3'd2: begin
              addr[7:0] <= rx;
              if (op == OP_READ) begin
                mem_addr <= {addr[AW-1:8], rx};
                rd1 <= 1'b1;
              end
            end
            default: begin
              if (op == OP_FAST && bidx == 3'd3) begin
                mem_addr <= addr;
                rd1 <= 1'b1;
              end else if (is_rd) begin
                addr <= addr + 1'b1;
                mem_addr <= addr + 1'b1;
                rd1 <= 1'b1;
              end else if (op == OP_WRITE) begin
                if (wr_ok) begin
                  mem_we <= 1'b1;
                  mem_wdata <= rx;
                  mem_addr <= addr;
                end
                addr <= addr + 1'b1;
                wel_clr <= 1'b1;
              end
            end
          endcase
          if (op == OP_RDSR && bidx != 3'd0) osr <= status;
        end
      end
    end
  end
endmodule

// File: rtl/spi_sram_slave_chk.sv
module spi_sram_slave_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] addr,
  input logic          wel,
  input logic [1:0]    bp,
  input logic          nv_busy,
  input logic          hold_s,
  input logic          cs_idle,
  input logic [2:0]    bitcnt,
  input logic          nv_gnt,
  input logic          miso_oe
);
  assert_we_needs_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wel);

  assert_no_write_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !$past(nv_busy));

  assert_no_protected_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !((bp == 2'd3) || (bp == 2'd2 && mem_addr[AW-1]) ||
                 (bp == 2'd1 && mem_addr[AW-1] && mem_addr[AW-2])));

  assert_burst_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (addr == AW'(mem_addr + 1'b1)));

  assert_hold_keeps_pos_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_s && !cs_idle) |=> (cs_idle || $stable(bitcnt)));

  assert_grant_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    nv_gnt |-> !miso_oe);
endmodule

bind spi_sram_slave spi_sram_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr), .addr(addr),
  .wel(wel), .bp(bp), .nv_busy(nv_busy), .hold_s(hold_s), .cs_idle(cs_idle),
  .bitcnt(bitcnt), .nv_gnt(nv_gnt), .miso_oe(miso_oe)
);

// File: tb/sim_spi_sram_slave.sv
module sim_spi_sram_slave;
  localparam int HALF = 8;
  localparam int NV = 9;
  // {bp, wp, write addr, read addr, write data, expected readback}
  localparam logic [55:0] VEC [NV] = '{
    56'h0_1_0010_0010_A5_A5,
    56'h0_1_7FFF_7FFF_3C_3C,
    56'h1_1_6000_6000_11_00,
    56'h1_1_5FFF_5FFF_22_22,
    56'h2_1_4000_4000_33_00,
    56'h2_1_3FFF_3FFF_44_44,
    56'h3_1_0020_0020_55_00,
    56'h0_0_0030_0030_66_00,
    56'h0_1_8040_0040_77_77
  };

  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, mosi = 0, hold_n = 1, wp_n = 1;
  logic miso, miso_oe, mem_we, nv_gnt;
  logic [14:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 0;
  logic nv_req = 0, nv_busy = 0;
  logic cpol = 0;
  int n_cmp = 0, n_bad = 0;
  logic [7:0] mem [int];

  always #5 clk = ~clk;

  spi_sram_slave u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .hold_n(hold_n),
    .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .nv_req(nv_req), .nv_gnt(nv_gnt),
    .nv_busy(nv_busy)
  );

  always @(posedge clk) begin
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input int n, input logic [7:0] tx, inout logic [7:0] rx);
    for (int i = 0; i < n; i++) begin
      sck = 0;
      mosi = tx[7];
      tx = tx << 1;
      waitc(HALF);
      rx = {rx[6:0], miso};
      sck = 1;
      waitc(HALF);
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    logic [7:0] r = 0;
    bits(8, tx, r);
    rx = r;
  endtask

  task automatic fbeg;
    sck = cpol;
    waitc(2);
    cs_n = 0;
    waitc(HALF);
  endtask

  task automatic fend;
    if (!cpol) sck = 0;
    waitc(HALF);
    cs_n = 1;
    waitc(2 * HALF);
  endtask

  task automatic cmd(input logic [7:0] o);
    logic [7:0] d;
    fbeg(); xb(o, d); fend();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] v);
    logic [7:0] d;
    fbeg(); xb(8'h02, d); xb(a[15:8], d); xb(a[7:0], d); xb(v, d); fend();
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    logic [7:0] d;
    fbeg(); xb(8'h03, d); xb(a[15:8], d); xb(a[7:0], d); xb(8'h00, v); fend();
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] d;
    fbeg(); xb(8'h05, d); xb(8'h00, v); fend();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    fbeg(); xb(8'h01, d); xb(v, d); fend();
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d, s;
    waitc(4);
    rst_n = 1;
    waitc(8);
    chk("R12 reset oe", {7'b0, miso_oe}, 8'h00);
    chk("R14 reset gnt", {7'b0, nv_gnt}, 8'h00);
    rdsr(s); chk("R8 reset status", s, 8'h00);

    for (int k = 0; k < NV; k++) begin
      logic [55:0] v = VEC[k];
      wp_n = 1;
      cmd(8'h06);
      wrsr({4'b0, v[53:52], 2'b00});
      rdsr(s); chk("R9 bp field", s, {4'b0, v[53:52], 2'b00});
      wp_n = v[48];
      cmd(8'h06);
      wr(v[47:32], v[15:8]);
      wp_n = 1;
      rd(v[31:16], d);
      chk("R10/R11/R2 table readback", d, v[7:0]);
    end

    cmd(8'h06); rdsr(s); chk("R6 wren status", s, 8'h02);
    cmd(8'h04); rdsr(s); chk("R6 wrdi status", s, 8'h00);
    wr(16'h0100, 8'h42); rd(16'h0100, d); chk("R6 write without latch", d, 8'h00);

    cmd(8'h06);
    fbeg(); xb(8'h02, d); xb(8'h7F, d); xb(8'hFE, d);
    xb(8'hC1, d); xb(8'hC2, d); xb(8'hC3, d); xb(8'hC4, d); fend();
    rdsr(s); chk("R7 latch cleared after write", s, 8'h00);
    fbeg(); xb(8'h03, d); xb(8'h7F, d); xb(8'hFE, d);
    xb(0, d); chk("R5 burst 7FFE", d, 8'hC1);
    xb(0, d); chk("R5 burst 7FFF", d, 8'hC2);
    xb(0, d); chk("R5 burst wrap 0000", d, 8'hC3);
    xb(0, d); chk("R5 burst 0001", d, 8'hC4);
    fend();

    fbeg(); xb(8'h0B, d); xb(8'h7F, d); xb(8'hFF, d); xb(8'h5A, d);
    xb(0, d); chk("R3 fast read 7FFF", d, 8'hC2);
    xb(0, d); chk("R3 fast read wrap", d, 8'hC3);
    fend();

    cpol = 1;
    rd(16'h0010, d); chk("R1 mode 3 read", d, 8'hA5);
    cmd(8'h06); wr(16'h0050, 8'h5A); rd(16'h0050, d); chk("R1 mode 3 write", d, 8'h5A);
    cpol = 0;

    cmd(8'h06);
    fbeg(); xb(8'h02, d); xb(8'h02, d); xb(8'h00, d); xb(8'h99, d);
    d = 0; bits(4, 8'hF0, d); fend();
    rd(16'h0200, d); chk("R4 full byte kept", d, 8'h99);
    rd(16'h0201, d); chk("R4 partial byte dropped", d, 8'h00);

    wrsr(8'h0C); rdsr(s); chk("R9 status write without latch", s, 8'h00);
    cmd(8'h06); wp_n = 0; wrsr(8'h0C); wp_n = 1;
    rdsr(s); chk("R11 status write under wp", s, 8'h00);

    fbeg(); xb(8'h03, d); xb(8'h00, d); xb(8'h10, d);
    d = 0; bits(4, 8'h00, d);
    hold_n = 0; waitc(4);
    chk("R12 oe low in hold", {7'b0, miso_oe}, 8'h00);
    for (int p = 0; p < 4; p++) begin sck = 0; waitc(3); sck = 1; waitc(3); end
    hold_n = 1; waitc(4);
    chk("R12 oe back after hold", {7'b0, miso_oe}, 8'h01);
    bits(4, 8'h00, d); fend();
    chk("R12 data across hold", d, 8'hA5);

    nv_busy = 1;
    rdsr(s); chk("R8 ready bit busy", s, 8'h01);
    rd(16'h0010, d); chk("R13 read during busy", d, 8'h00);
    cmd(8'h06); wr(16'h0300, 8'hAB);
    nv_busy = 0;
    rd(16'h0300, d); chk("R13 write during busy dropped", d, 8'h00);

    nv_req = 1; waitc(4);
    chk("R14 grant when idle", {7'b0, nv_gnt}, 8'h01);
    fbeg(); waitc(4);
    chk("R14 no grant in frame", {7'b0, nv_gnt}, 8'h00);
    fend(); nv_req = 0;

    finish_run();
  end
endmodule